// File: doc/BRIEF.md
# Protected Clock-Control Register Bank

This block is a small bank of system clock control registers on a single-cycle synchronous register port. A protect register with two independent enable bits decides which writes land. One enable bit opens the peripheral clock select register and the four clock-control shadow registers. The other opens the processor-mode register, which holds the wait-state select and three lock bits that can be set once and cannot be cleared by software.

The clock-modification lock freezes a fixed set of main-clock, auxiliary-clock, oscillator-detect and PLL control bits. While it is set, the bus clock also keeps running during a wait instruction. The watchdog-source lock moves the watchdog count source to the on-chip oscillator, starts that oscillator and keeps the watchdog counting in wait mode. It also blocks stop-mode entry. The wait-state select can only change while the PLL is off. The third lock enables the NMI function of a shared pin.

Only a system reset returns the locks and registers to their reset values. The clock-control shadow registers drive the clock generator. An accepted stop command produces a one-cycle request pulse.

Top module: `clk_ctl_bank`

## Requirements
- R1: After reset, every register reads 0 except the peripheral clock select register, which reads 0x03. All single-bit outputs are 0, except timerClkDiv1 and serialClkDiv1, which are 1.
- R2: The protect register at address 0 can always be written. Bits 1:0 are stored and read back, and bits 7:2 read 0.
- R3: A write to the peripheral clock select register (address 1) is applied only while protect bit 0 is 1. Only bits 0, 1 and 5 are stored; the rest read 0. Bit 0 drives timerClkDiv1, bit 1 drives serialClkDiv1 and bit 5 drives clkOutExp.
- R4: A write to the mode register (address 2) is applied only while protect bit 1 is 1. Bits 3 and 7:5 always read 0.
- R5: Mode bit 0 (waitOneCycle; 1 = one wait state, 0 = two) changes only on a mode write made while PLL control bit 7 (PLL on) is 0. Otherwise the bit is kept.
- R6: Mode bits 1, 2 and 4 are write-once. A write of 0 leaves a 1 in place until the next reset.
- R7: While mode bit 1 is 1, busClkKeep is 1 and writes are ignored to clock-control-0 bits 2, 5 and 7, clock-control-1 bit 1, clock-control-2 bit 0 and all PLL control bits. Other clock-control bits stay writable.
- R8: While mode bit 2 is 1, wdtSrcOsc, intOscRun and wdtRunInWait are 1, and a stop command is ignored.
- R9: An applied write to clock-control-1 (address 4) with data bit 0 set is a stop command. It raises stopReq for exactly the one cycle after the write edge. Bit 0 itself reads 0, and a stop command is also ignored while mode bit 1 is 1.
- R10: Writes to clock-control 0, 1, 2 and PLL control (addresses 3, 4, 5, 6) are applied only while protect bit 0 is 1. These registers drive the matching shadow outputs.
- R11: Mode bit 4 drives nmiEnable.
- R12: A read of address 7 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| addr | input | ADDR_W | Register address |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data |
| timerClkDiv1 | output | 1 | Timer clock source: 1 = f/1, 0 = f/2 |
| serialClkDiv1 | output | 1 | Serial clock source: 1 = f/1, 0 = f/2 |
| clkOutExp | output | 1 | Clock-output expansion select |
| waitOneCycle | output | 1 | Register access wait: 1 = one wait state |
| busClkKeep | output | 1 | Keep the bus clock running in wait |
| wdtSrcOsc | output | 1 | Watchdog counts the on-chip oscillator |
| intOscRun | output | 1 | Start the on-chip oscillator |
| wdtRunInWait | output | 1 | Watchdog keeps counting in wait mode |
| nmiEnable | output | 1 | Shared pin works as NMI |
| stopReq | output | 1 | One-cycle stop-mode request |
| clkCtl0Out | output | 8 | Clock-control-0 shadow |
| clkCtl1Out | output | 8 | Clock-control-1 shadow |
| clkCtl2Out | output | 8 | Clock-control-2 shadow |
| pllCtlOut | output | 8 | PLL control shadow |

## Verification
A wrong internal state shows up on the cycle after the write edge that caused it. A lock bit that clears shows up at once on the lock outputs and in the mode readback. A wrong write mask leaves a frozen bit changed in the shadow output and readback right away. A stop command that should have been blocked shows up as a stray stopReq pulse in the cycle after the write.

// File: rtl/clk_ctl_pkg.sv
package clk_ctl_pkg;
  localparam logic [7:0] PER_MASK   = 8'h23;
  localparam logic [7:0] CC0_FROZEN = 8'hA4;
  localparam logic [7:0] CC1_FROZEN = 8'h02;
  localparam logic [7:0] CC2_FROZEN = 8'h01;
  localparam logic [7:0] CC1_STORE  = 8'hFE;
  localparam int PLL_ON_BIT = 7;

  localparam int A_PROT = 0;
  localparam int A_PER  = 1;
  localparam int A_MODE = 2;
  localparam int A_CC0  = 3;
  localparam int A_CC1  = 4;
  localparam int A_CC2  = 5;
  localparam int A_PLL  = 6;

  typedef struct packed {
    logic       wrProt;
    logic       wrPer;
    logic       wrMode;
    logic       wrWait;
    logic [7:0] cc0Mask;
    logic [7:0] cc1Mask;
    logic [7:0] cc2Mask;
    logic       wrPll;
    logic       stopCmd;
  } strobe_t;
endpackage

// File: rtl/clk_ctl_ctrl.sv
module clk_ctl_ctrl
  import clk_ctl_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              stopBit,
  input  logic [1:0]        prot,
  input  logic              clkLock,
  input  logic              wdtLock,
  input  logic              pllOn,
  output strobe_t           strb
);
  logic selPer, selMode, selCc0, selCc1, selCc2, selPll, openClk, openMode;

  always_comb begin
    selPer   = wrEn && (addr == ADDR_W'(A_PER));
    selMode  = wrEn && (addr == ADDR_W'(A_MODE));
    selCc0   = wrEn && (addr == ADDR_W'(A_CC0));
    selCc1   = wrEn && (addr == ADDR_W'(A_CC1));
    selCc2   = wrEn && (addr == ADDR_W'(A_CC2));
    selPll   = wrEn && (addr == ADDR_W'(A_PLL));
    openClk  = prot[0];
    openMode = prot[1];

    strb.wrProt  = wrEn && (addr == ADDR_W'(A_PROT));
    strb.wrPer   = selPer && openClk;
    strb.wrMode  = selMode && openMode;
    strb.wrWait  = selMode && openMode && !pllOn;
    strb.cc0Mask = (selCc0 && openClk) ? (clkLock ? ~CC0_FROZEN : 8'hFF) : 8'h00;
    strb.cc1Mask = (selCc1 && openClk) ? (CC1_STORE & (clkLock ? ~CC1_FROZEN : 8'hFF)) : 8'h00;
    strb.cc2Mask = (selCc2 && openClk) ? (clkLock ? ~CC2_FROZEN : 8'hFF) : 8'h00;
    strb.wrPll   = selPll && openClk && !clkLock;
    strb.stopCmd = selCc1 && openClk && stopBit && !clkLock && !wdtLock;
  end

  // R8, R9: a locked bank never issues a stop command
  a_r9_stop_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (clkLock || wdtLock) |-> !strb.stopCmd);
  // R10: closed protect bit 0 lets no clock-control write through
  a_r10_closed_no_write: assert property (@(posedge clk) disable iff (!rstN)
    !prot[0] |-> (strb.cc0Mask == 8'h00 && strb.cc1Mask == 8'h00 &&
                  strb.cc2Mask == 8'h00 && !strb.wrPll && !strb.wrPer));
endmodule

// File: rtl/clk_ctl_dp.sv
module clk_ctl_dp
  import clk_ctl_pkg::*;
#(
  parameter int         ADDR_W  = 3,
  parameter logic [7:0] PER_RST = 8'h03
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  strobe_t           strb,
  output logic [7:0]        rdData,
  output logic [1:0]        prot,
  output logic [7:0]        perReg,
  output logic              waitSel,
  output logic              clkLock,
  output logic              wdtLock,
  output logic              nmiEn,
  output logic [7:0]        cc0Reg,
  output logic [7:0]        cc1Reg,
  output logic [7:0]        cc2Reg,
  output logic [7:0]        pllReg,
  output logic              stopPulse
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prot      <= 2'b00;
      perReg    <= PER_RST & PER_MASK;
      waitSel   <= 1'b0;
      clkLock   <= 1'b0;
      wdtLock   <= 1'b0;
      nmiEn     <= 1'b0;
      cc0Reg    <= 8'h00;
      cc1Reg    <= 8'h00;
      cc2Reg    <= 8'h00;
      pllReg    <= 8'h00;
      stopPulse <= 1'b0;
    end else begin
      if (strb.wrProt) prot <= wrData[1:0];
      if (strb.wrPer)  perReg <= wrData & PER_MASK;
      if (strb.wrWait) waitSel <= wrData[0];
      if (strb.wrMode) begin
        clkLock <= clkLock | wrData[1];
        wdtLock <= wdtLock | wrData[2];
        nmiEn   <= nmiEn | wrData[4];
      end
      cc0Reg    <= (cc0Reg & ~strb.cc0Mask) | (wrData & strb.cc0Mask);
      cc1Reg    <= (cc1Reg & ~strb.cc1Mask) | (wrData & strb.cc1Mask);
      cc2Reg    <= (cc2Reg & ~strb.cc2Mask) | (wrData & strb.cc2Mask);
      if (strb.wrPll) pllReg <= wrData;
      stopPulse <= strb.stopCmd;
    end
  end

  always_comb begin
    case (int'(addr))
      A_PROT:  rdData = {6'b0, prot};
      A_PER:   rdData = perReg;
      A_MODE:  rdData = {3'b0, nmiEn, 1'b0, wdtLock, clkLock, waitSel};
      A_CC0:   rdData = cc0Reg;
      A_CC1:   rdData = cc1Reg;
      A_CC2:   rdData = cc2Reg;
      A_PLL:   rdData = pllReg;
      default: rdData = 8'h00;
    endcase
  end

  a_r6_clk_lock_sticky: assert property (@(posedge clk) disable iff (!rstN)
    clkLock |=> clkLock);
  a_r6_wdt_lock_sticky: assert property (@(posedge clk) disable iff (!rstN)
    wdtLock |=> wdtLock);
  a_r11_nmi_sticky: assert property (@(posedge clk) disable iff (!rstN)
    nmiEn |=> nmiEn);
  a_r5_wait_frozen: assert property (@(posedge clk) disable iff (!rstN)
    pllReg[PLL_ON_BIT] |=> $stable(waitSel));
  a_r7_pll_frozen: assert property (@(posedge clk) disable iff (!rstN)
    clkLock |=> $stable(pllReg));
  a_r7_cc0_frozen: assert property (@(posedge clk) disable iff (!rstN)
    clkLock |=> $stable(cc0Reg & CC0_FROZEN));
  a_r3_per_reserved: assert property (@(posedge clk) disable iff (!rstN)
    (perReg & ~PER_MASK) == 8'h00);
  a_r9_stop_bit_clear: assert property (@(posedge clk) disable iff (!rstN)
    !cc1Reg[0]);
endmodule

// File: rtl/clk_ctl_bank.sv
module clk_ctl_bank
  import clk_ctl_pkg::*;
#(
  parameter int         ADDR_W  = 3,
  parameter logic [7:0] PER_RST = 8'h03
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              timerClkDiv1,
  output logic              serialClkDiv1,
  output logic              clkOutExp,
  output logic              waitOneCycle,
  output logic              busClkKeep,
  output logic              wdtSrcOsc,
  output logic              intOscRun,
  output logic              wdtRunInWait,
  output logic              nmiEnable,
  output logic              stopReq,
  output logic [7:0]        clkCtl0Out,
  output logic [7:0]        clkCtl1Out,
  output logic [7:0]        clkCtl2Out,
  output logic [7:0]        pllCtlOut
);
  strobe_t    strb;
  logic [1:0] prot;
  logic [7:0] perReg;
  logic       waitSel, clkLock, wdtLock, nmiEn;

  clk_ctl_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .stopBit(wrData[0]),
    .prot(prot), .clkLock(clkLock), .wdtLock(wdtLock),
    .pllOn(pllCtlOut[PLL_ON_BIT]), .strb(strb)
  );

  clk_ctl_dp #(.ADDR_W(ADDR_W), .PER_RST(PER_RST)) uDp (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .strb(strb),
    .rdData(rdData), .prot(prot), .perReg(perReg), .waitSel(waitSel),
    .clkLock(clkLock), .wdtLock(wdtLock), .nmiEn(nmiEn),
    .cc0Reg(clkCtl0Out), .cc1Reg(clkCtl1Out), .cc2Reg(clkCtl2Out),
    .pllReg(pllCtlOut), .stopPulse(stopReq)
  );

  assign timerClkDiv1  = perReg[0];
  assign serialClkDiv1 = perReg[1];
  assign clkOutExp     = perReg[5];
  assign waitOneCycle  = waitSel;
  assign busClkKeep    = clkLock;
  assign wdtSrcOsc     = wdtLock;
  assign intOscRun     = wdtLock;
  assign wdtRunInWait  = wdtLock;
  assign nmiEnable     = nmiEn;

  // R8: a stop request never leaves a locked bank
  a_r8_no_stop_locked: assert property (@(posedge clk) disable iff (!rstN)
    $past(wdtLock) |-> !stopReq);
endmodule

// File: tb/tb_clk_ctl_bank.sv
module tb_clk_ctl_bank;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] addr = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData, clkCtl0Out, clkCtl1Out, clkCtl2Out, pllCtlOut;
  logic timerClkDiv1, serialClkDiv1, clkOutExp, waitOneCycle, busClkKeep;
  logic wdtSrcOsc, intOscRun, wdtRunInWait, nmiEnable, stopReq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_ctl_bank dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .timerClkDiv1(timerClkDiv1), .serialClkDiv1(serialClkDiv1),
    .clkOutExp(clkOutExp), .waitOneCycle(waitOneCycle), .busClkKeep(busClkKeep),
    .wdtSrcOsc(wdtSrcOsc), .intOscRun(intOscRun), .wdtRunInWait(wdtRunInWait),
    .nmiEnable(nmiEnable), .stopReq(stopReq), .clkCtl0Out(clkCtl0Out),
    .clkCtl1Out(clkCtl1Out), .clkCtl2Out(clkCtl2Out), .pllCtlOut(pllCtlOut)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    doReset();
    // R1 reset state
    rd(0, r); chk("R1 prot", r, 8'h00);
    rd(1, r); chk("R1 per", r, 8'h03);
    rd(2, r); chk("R1 mode", r, 8'h00);
    for (int a = 3; a < 7; a++) begin rd(3'(a), r); chk("R1 clkctl", r, 8'h00); end
    chk("R1 outs", {timerClkDiv1, serialClkDiv1, clkOutExp, waitOneCycle, busClkKeep,
                    wdtSrcOsc, nmiEnable, stopReq}, 8'b1100_0000);
    // R12
    rd(7, r); chk("R12 unmapped", r, 8'h00);
    // R2 protect sweep
    for (int v = 0; v < 256; v++) begin
      wr(0, 8'(v)); rd(0, r); chk("R2 prot", r, 8'(v) & 8'h03);
    end
    wr(0, 8'h00);
    // R3 closed
    wr(1, 8'hFF); rd(1, r); chk("R3 closed", r, 8'h03);
    // R10 closed
    for (int a = 3; a < 7; a++) begin
      wr(3'(a), 8'hFF); rd(3'(a), r); chk("R10 closed", r, 8'h00);
    end
    chk("R9 closed nostop", {7'b0, stopReq}, 8'h00);
    wr(0, 8'h01);
    // R3 open sweep
    for (int v = 0; v < 256; v++) begin
      wr(1, 8'(v)); rd(1, r); chk("R3 per", r, 8'(v) & 8'h23);
      chk("R3 outs", {5'b0, clkOutExp, serialClkDiv1, timerClkDiv1},
          {5'b0, v[5], v[1], v[0]});
    end
    // R10 open sweeps
    for (int v = 0; v < 256; v++) begin
      wr(3, 8'(v)); rd(3, r); chk("R10 cc0", r, 8'(v));
      wr(5, 8'(v)); rd(5, r); chk("R10 cc2", r, 8'(v));
      wr(6, 8'(v & 8'h7F)); rd(6, r); chk("R10 pll", r, 8'(v) & 8'h7F);
      chk("R10 pll out", pllCtlOut, 8'(v) & 8'h7F);
      wr(4, 8'(v & 8'hFE)); rd(4, r); chk("R10 cc1", r, 8'(v) & 8'hFE);
    end
    wr(6, 8'h00);
    // R4 mode protected by bit 1
    wr(2, 8'h01); rd(2, r); chk("R4 closed", r, 8'h00);
    wr(0, 8'h03);
    wr(2, 8'hE9); rd(2, r); chk("R4 reserved", r, 8'h01);
    chk("R5 wait out", {7'b0, waitOneCycle}, 8'h01);
    // R5 wait frozen with PLL on
    wr(6, 8'h80);
    wr(2, 8'h00); rd(2, r); chk("R5 pll on keep", r, 8'h01);
    wr(6, 8'h00);
    wr(2, 8'h00); rd(2, r); chk("R5 pll off write", r, 8'h00);
    // R9 stop pulse
    @(negedge clk); addr = 4; wrData = 8'h01; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
    chk("R9 pulse high", {7'b0, stopReq}, 8'h01);
    @(negedge clk);
    chk("R9 pulse low", {7'b0, stopReq}, 8'h00);
    rd(4, r); chk("R9 bit0 reads 0", r, 8'h00);
    wr(4, 8'h00); chk("R9 no pulse", {7'b0, stopReq}, 8'h00);
    // R11 and R6 nmi lock
    wr(2, 8'h10); rd(2, r); chk("R11 nmi", r, 8'h10);
    chk("R11 nmi out", {7'b0, nmiEnable}, 8'h01);
    wr(2, 8'h00); rd(2, r); chk("R6 nmi sticky", r, 8'h10);
    // R8 watchdog lock
    wr(2, 8'h04); rd(2, r); chk("R8 wdt set", r, 8'h14);
    chk("R8 outs", {5'b0, wdtSrcOsc, intOscRun, wdtRunInWait}, 8'h07);
    wr(2, 8'h00); rd(2, r); chk("R6 wdt sticky", r, 8'h14);
    wr(4, 8'h01); chk("R8 stop ignored", {7'b0, stopReq}, 8'h00);
    wr(4, 8'h02); rd(4, r); chk("R8 cc1 bit1 open", r, 8'h02);
    // R7 clock lock
    wr(3, 8'h00); wr(5, 8'h00); wr(6, 8'h00);
    wr(2, 8'h02); rd(2, r); chk("R7 lock set", r, 8'h16);
    chk("R7 busClkKeep", {7'b0, busClkKeep}, 8'h01);
    for (int v = 0; v < 256; v++) begin
      wr(3, 8'(v)); rd(3, r); chk("R7 cc0 mask", r, 8'(v) & 8'h5B);
    end
    wr(4, 8'hFF); rd(4, r); chk("R7 cc1 ff", r, 8'hFE);
    wr(4, 8'h00); rd(4, r); chk("R7 cc1 00", r, 8'h02);
    wr(5, 8'hFF); rd(5, r); chk("R7 cc2", r, 8'hFE);
    wr(6, 8'hFF); rd(6, r); chk("R7 pll", r, 8'h00);
    wr(2, 8'h00); rd(2, r); chk("R6 clk sticky", r, 8'h16);
    wr(2, 8'h01); rd(2, r); chk("R5 wait locked bank", r, 8'h17);
    // R1 reset clears locks
    doReset();
    rd(2, r); chk("R1 locks cleared", r, 8'h00);
    rd(3, r); chk("R1 cc0 cleared", r, 8'h00);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule